// File: doc/BRIEF.md
# Bank-Locking Launch/Poll Front End for Processing-in-Memory

This block is a command front end for a memory controller. Each bank of memory has a processing-in-memory (PIM) unit attached to it. A single command port carries four kinds of operation: ordinary CPU reads, ordinary CPU writes, task launches and status polls. CPU accesses are routed to a per-bank issue port.

A launch starts a task on one bank's PIM unit, and each task runs in two phases:

- **Load phase.** The bank is locked. The controller issues a programmed number of bulk-load beats on that bank's issue port, and these beats fill the unit's working memory.
- **Compute phase.** The bank unlocks. CPU traffic to the bank resumes while the unit computes internally.

While a bank is locked, CPU accesses to it wait in a small per-bank queue. Accesses to other banks are not delayed. Each PIM unit signals completion with a done pulse. A poll returns one bitmask that covers every task slot, where slot i is bank i, and the poll clears the bits it reports. This lets CPU and PIM work interleave operator by operator, with no per-unit status queries.

Top module: `pim_lock_ctrl`

## Requirements
- R1: After reset, no issue port is valid, no response is valid, `cmd_ready` is high, and a poll returns an all-zero mask.
- R2: Opcodes are 0 = read, 1 = write, 2 = launch, 3 = poll. A read or write that is accepted for an unlocked bank with an empty queue appears on that bank's issue port in the cycle after acceptance. It carries its address and data, with issue kind 0 for a read and 1 for a write.
- R3: An accepted launch with N beats (N ≥ 1) returns a response with `rsp_err` = 0 in the cycle after acceptance. It then issues exactly N load beats, issue kind 2, on consecutive cycles, with addresses base, base+1, and so on. The first beat appears two cycles after acceptance.
- R4: A CPU access to a locked bank is queued. Queued accesses issue one per cycle in arrival order, and the first one issues in the cycle after the last load beat. Banks that are not locked keep issuing without delay.
- R5: During the compute phase the bank is unlocked, and CPU accesses issue directly as in R2.
- R6: A launch to a bank whose task is in its load or compute phase is rejected with `rsp_err` = 1 and issues no load beats. A launch with zero beats is also rejected.
- R7: A done pulse records completion only while its bank is in the compute phase. At any other time it is ignored.
- R8: A poll returns `rsp_mask` with bit i set for each bank i that has completed and has not yet been reported, then clears those bits. A completion that arrives in the same cycle as a poll is reported by the next poll. A completed bank accepts a new launch.
- R9: `cmd_ready` is low while a read or write targets a bank whose queue is full. It stays high for other banks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command can be accepted |
| cmd_op | input | 2 | Opcode (0 read, 1 write, 2 launch, 3 poll) |
| cmd_bank | input | BANK_W | Target bank |
| cmd_addr | input | ADDR_W | Access address or load base address |
| cmd_wdata | input | DATA_W | Write data |
| cmd_beats | input | BEAT_W | Load-phase beat count for a launch |
| pim_done | input | NUM_BANKS | Completion pulse per bank |
| rsp_valid | output | 1 | Launch or poll response valid |
| rsp_err | output | 1 | Launch rejected |
| rsp_mask | output | NUM_BANKS | Poll completion mask |
| iss_valid | output | NUM_BANKS | Issue valid per bank |
| iss_kind | output | 2*NUM_BANKS | Issue kind per bank (0 read, 1 write, 2 load) |
| iss_addr | output | ADDR_W*NUM_BANKS | Issue address per bank |
| iss_wdata | output | DATA_W*NUM_BANKS | Issue write data per bank |

## Verification
The bench places CPU accesses to a bank in the same cycles as that bank's load beats. A design that leaked them through would break atomicity, and one that reordered or dropped them would show the wrong address after the lock lifts. It sends done pulses while a bank is idle or still loading, where a loose design would report false completions. It launches into a busy bank and launches with zero beats, and either case accepted would start stray load beats. It raises a completion in the very cycle of a poll, which catches a design that clears the bit without ever reporting it. It also fills a queue to check that `cmd_ready` falls only for that bank.

// File: rtl/pim_lc_pkg.sv
package pim_lc_pkg;
  typedef enum logic [1:0] {OP_RD = 2'd0, OP_WR = 2'd1, OP_LAUNCH = 2'd2, OP_POLL = 2'd3} op_e;
  typedef enum logic [1:0] {ISS_RD = 2'd0, ISS_WR = 2'd1, ISS_LOAD = 2'd2} iss_e;
  typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_LOAD = 2'd1, ST_COMPUTE = 2'd2} bank_st_e;
endpackage

// File: rtl/pim_bank_fifo.sv
module pim_bank_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  output logic [WIDTH-1:0] dout,
  output logic             empty,
  output logic             full
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] count;

  assign empty = (count == '0);
  assign full  = (count == CNT_W'(DEPTH));
  assign dout  = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (pop)  rd_ptr <= (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      count <= count + CNT_W'(push) - CNT_W'(pop);
    end
  end

  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (rst) !(push && full && !pop));
  assert_no_underflow_R4: assert property (@(posedge clk) disable iff (rst) !(pop && empty));
endmodule

// File: rtl/pim_bank_ctrl.sv
module pim_bank_ctrl
  import pim_lc_pkg::*;
#(
  parameter int ADDR_W  = 12,
  parameter int DATA_W  = 16,
  parameter int BEAT_W  = 8,
  parameter int Q_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              launch_go,
  input  logic [ADDR_W-1:0] launch_base,
  input  logic [BEAT_W-1:0] launch_beats,
  input  logic              cpu_go,
  input  logic              cpu_write,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic              done_in,
  input  logic              clr_done,
  output logic              active,
  output logic              done_flag,
  output logic              q_full,
  output logic              iss_v,
  output logic [1:0]        iss_kind,
  output logic [ADDR_W-1:0] iss_addr,
  output logic [DATA_W-1:0] iss_wdata
);
  localparam int ENT_W = 1 + ADDR_W + DATA_W;

  bank_st_e          st;
  logic [BEAT_W-1:0] beats_left;
  logic [ADDR_W-1:0] ld_addr;
  logic              q_empty, q_push, q_pop;
  logic [ENT_W-1:0]  q_dout;
  logic              locked;

  assign locked = (st == ST_LOAD);
  assign active = (st != ST_IDLE);
  assign q_push = cpu_go && (locked || !q_empty);
  assign q_pop  = !locked && !q_empty;

  pim_bank_fifo #(.WIDTH(ENT_W), .DEPTH(Q_DEPTH)) u_fifo (
    .clk(clk), .rst(rst),
    .push(q_push), .din({cpu_write, cpu_addr, cpu_wdata}),
    .pop(q_pop), .dout(q_dout), .empty(q_empty), .full(q_full)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      beats_left <= '0;
      ld_addr    <= '0;
      done_flag  <= 1'b0;
    end else begin
      done_flag <= (done_flag && !clr_done) || (st == ST_COMPUTE && done_in);
      case (st)
        ST_IDLE: if (launch_go) begin
          st         <= ST_LOAD;
          beats_left <= launch_beats;
          ld_addr    <= launch_base;
          done_flag  <= 1'b0;
        end
        ST_LOAD: begin
          beats_left <= beats_left - 1'b1;
          ld_addr    <= ld_addr + 1'b1;
          if (beats_left == BEAT_W'(1)) st <= ST_COMPUTE;
        end
        ST_COMPUTE: if (done_in) st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      iss_v     <= 1'b0;
      iss_kind  <= ISS_RD;
      iss_addr  <= '0;
      iss_wdata <= '0;
    end else if (locked) begin
      iss_v     <= 1'b1;
      iss_kind  <= ISS_LOAD;
      iss_addr  <= ld_addr;
      iss_wdata <= '0;
    end else if (!q_empty) begin
      iss_v     <= 1'b1;
      iss_kind  <= q_dout[ENT_W-1] ? ISS_WR : ISS_RD;
      iss_addr  <= q_dout[DATA_W +: ADDR_W];
      iss_wdata <= q_dout[DATA_W-1:0];
    end else if (cpu_go) begin
      iss_v     <= 1'b1;
      iss_kind  <= cpu_write ? ISS_WR : ISS_RD;
      iss_addr  <= cpu_addr;
      iss_wdata <= cpu_wdata;
    end else begin
      iss_v <= 1'b0;
    end
  end

  assert_lock_blocks_cpu_R4: assert property (@(posedge clk) disable iff (rst)
    locked |=> (iss_v && iss_kind == ISS_LOAD));
  assert_done_ignored_R7: assert property (@(posedge clk) disable iff (rst)
    (st != ST_COMPUTE && !done_flag) |=> !done_flag);
  assert_compute_unlocked_R5: assert property (@(posedge clk) disable iff (rst)
    (st == ST_COMPUTE) |=> (st != ST_LOAD));
endmodule

// File: rtl/pim_lock_ctrl.sv
module pim_lock_ctrl
  import pim_lc_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int ADDR_W    = 12,
  parameter int DATA_W    = 16,
  parameter int BEAT_W    = 8,
  parameter int Q_DEPTH   = 4,
  localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        cmd_valid,
  output logic                        cmd_ready,
  input  logic [1:0]                  cmd_op,
  input  logic [BANK_W-1:0]           cmd_bank,
  input  logic [ADDR_W-1:0]           cmd_addr,
  input  logic [DATA_W-1:0]           cmd_wdata,
  input  logic [BEAT_W-1:0]           cmd_beats,
  input  logic [NUM_BANKS-1:0]        pim_done,
  output logic                        rsp_valid,
  output logic                        rsp_err,
  output logic [NUM_BANKS-1:0]        rsp_mask,
  output logic [NUM_BANKS-1:0]        iss_valid,
  output logic [2*NUM_BANKS-1:0]      iss_kind,
  output logic [ADDR_W*NUM_BANKS-1:0] iss_addr,
  output logic [DATA_W*NUM_BANKS-1:0] iss_wdata
);
  logic [NUM_BANKS-1:0] active, done_flags, q_full;
  logic is_cpu, cpu_ok, is_launch, launch_ok, is_poll;

  assign is_cpu    = (cmd_op == OP_RD) || (cmd_op == OP_WR);
  assign cmd_ready = !(is_cpu && q_full[cmd_bank]);
  assign cpu_ok    = cmd_valid && is_cpu && !q_full[cmd_bank];
  assign is_launch = cmd_valid && (cmd_op == OP_LAUNCH);
  assign launch_ok = is_launch && !active[cmd_bank] && (cmd_beats != '0);
  assign is_poll   = cmd_valid && (cmd_op == OP_POLL);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic sel;
    assign sel = (cmd_bank == BANK_W'(b));
    pim_bank_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BEAT_W(BEAT_W), .Q_DEPTH(Q_DEPTH)) u_bank (
      .clk(clk), .rst(rst),
      .launch_go(launch_ok && sel), .launch_base(cmd_addr), .launch_beats(cmd_beats),
      .cpu_go(cpu_ok && sel), .cpu_write(cmd_op == OP_WR),
      .cpu_addr(cmd_addr), .cpu_wdata(cmd_wdata),
      .done_in(pim_done[b]), .clr_done(is_poll && done_flags[b]),
      .active(active[b]), .done_flag(done_flags[b]), .q_full(q_full[b]),
      .iss_v(iss_valid[b]), .iss_kind(iss_kind[2*b +: 2]),
      .iss_addr(iss_addr[ADDR_W*b +: ADDR_W]), .iss_wdata(iss_wdata[DATA_W*b +: DATA_W])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_mask  <= '0;
    end else begin
      rsp_valid <= is_launch || is_poll;
      rsp_err   <= is_launch && !launch_ok;
      rsp_mask  <= is_poll ? done_flags : '0;
    end
  end

  assert_busy_reject_R6: assert property (@(posedge clk) disable iff (rst)
    (is_launch && active[cmd_bank]) |=> (rsp_valid && rsp_err));
  assert_poll_clears_R8: assert property (@(posedge clk) disable iff (rst)
    is_poll |=> ((done_flags & rsp_mask) == '0));
  assert_launch_locks_R3: assert property (@(posedge clk) disable iff (rst)
    launch_ok |=> active[$past(cmd_bank)]);
endmodule

// File: tb/test_pim_lock_ctrl.sv
`timescale 1ns/1ps
module test_pim_lock_ctrl;
  localparam int NB = 4, AW = 12, DW = 16, BW = 8, BKW = 2;

  logic clk = 0, rst = 1;
  logic cmd_valid = 0, cmd_ready;
  logic [1:0] cmd_op = 0;
  logic [BKW-1:0] cmd_bank = 0;
  logic [AW-1:0] cmd_addr = 0;
  logic [DW-1:0] cmd_wdata = 0;
  logic [BW-1:0] cmd_beats = 0;
  logic [NB-1:0] pim_done = 0;
  logic rsp_valid, rsp_err;
  logic [NB-1:0] rsp_mask, iss_valid;
  logic [2*NB-1:0] iss_kind;
  logic [AW*NB-1:0] iss_addr;
  logic [DW*NB-1:0] iss_wdata;
  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  pim_lock_ctrl i_pim_lock_ctrl (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic send(input int op, input int bank, input int addr, input int data,
                      input int beats, input logic [NB-1:0] done = '0);
    @(negedge clk);
    cmd_valid = 1; cmd_op = op[1:0]; cmd_bank = bank[BKW-1:0];
    cmd_addr = addr[AW-1:0]; cmd_wdata = data[DW-1:0]; cmd_beats = beats[BW-1:0];
    pim_done = done;
    @(posedge clk); #1;
    cmd_valid = 0; pim_done = '0;
  endtask

  task automatic pulse_done(input logic [NB-1:0] d);
    @(negedge clk); pim_done = d;
    @(posedge clk); #1; pim_done = '0;
  endtask

  task automatic chk_iss(input int b, input bit v, input int kind, input int addr,
                         input int data, input string req);
    chk(iss_valid[b] == v, {req, " valid"}, iss_valid[b], v);
    if (v) begin
      chk(iss_kind[2*b +: 2] == kind[1:0], {req, " kind"}, iss_kind[2*b +: 2], kind);
      chk(iss_addr[AW*b +: AW] == addr[AW-1:0], {req, " addr"}, iss_addr[AW*b +: AW], addr);
      if (kind == 1)
        chk(iss_wdata[DW*b +: DW] == data[DW-1:0], {req, " data"}, iss_wdata[DW*b +: DW], data);
    end
  endtask

  task automatic chk_rsp(input bit err, input int mask, input string req);
    chk(rsp_valid == 1'b1, {req, " rsp_valid"}, rsp_valid, 1);
    chk(rsp_err == err, {req, " rsp_err"}, rsp_err, err);
    chk(rsp_mask == mask[NB-1:0], {req, " rsp_mask"}, rsp_mask, mask);
  endtask

  task automatic t_reset(); // R1
    chk(iss_valid == '0, "R1 no issue", iss_valid, 0);
    chk(rsp_valid == 1'b0, "R1 no rsp", rsp_valid, 0);
    chk(cmd_ready == 1'b1, "R1 ready", cmd_ready, 1);
    send(3, 0, 0, 0, 0);
    chk_rsp(0, 0, "R1 poll");
  endtask

  task automatic t_direct(); // R2
    send(0, 0, 3, 0, 0);
    chk_iss(0, 1, 0, 3, 0, "R2 read");
    send(1, 3, 4, 16'hBEEF, 0);
    chk_iss(3, 1, 1, 4, 16'hBEEF, "R2 write");
    chk_iss(0, 0, 0, 0, 0, "R2 one-shot");
  endtask

  task automatic t_lock(); // R3 R4
    send(2, 1, 12'h40, 0, 3);
    chk_rsp(0, 0, "R3 launch ok");
    chk_iss(1, 0, 0, 0, 0, "R3 no beat yet");
    send(1, 1, 5, 16'h00AA, 0);
    chk_iss(1, 1, 2, 12'h40, 0, "R3 beat0");
    send(0, 1, 6, 0, 0);
    chk_iss(1, 1, 2, 12'h41, 0, "R3 beat1");
    send(1, 2, 7, 16'h0055, 0);
    chk_iss(1, 1, 2, 12'h42, 0, "R3 beat2");
    chk_iss(2, 1, 1, 7, 16'h0055, "R4 other bank direct");
    tick();
    chk_iss(1, 1, 1, 5, 16'h00AA, "R4 queued first");
    tick();
    chk_iss(1, 1, 0, 6, 0, "R4 queued second");
    tick();
    chk_iss(1, 0, 0, 0, 0, "R3 exactly N beats");
  endtask

  task automatic t_compute(); // R5 R6
    send(1, 1, 9, 16'h1234, 0);
    chk_iss(1, 1, 1, 9, 16'h1234, "R5 compute direct");
    send(2, 1, 12'h80, 0, 2);
    chk_rsp(1, 0, "R6 busy reject");
    tick();
    chk_iss(1, 0, 0, 0, 0, "R6 no beats");
    send(2, 3, 12'h10, 0, 0);
    chk_rsp(1, 0, "R6 zero beats");
    tick();
    chk_iss(3, 0, 0, 0, 0, "R6 zero no beats");
  endtask

  task automatic t_done(); // R7 R8
    pulse_done(4'b0001);
    send(3, 0, 0, 0, 0);
    chk_rsp(0, 0, "R7 idle done ignored");
    send(2, 0, 12'h20, 0, 2);
    pulse_done(4'b0001);
    tick();
    send(3, 0, 0, 0, 0);
    chk_rsp(0, 0, "R7 load done ignored");
    pulse_done(4'b0011);
    send(3, 0, 0, 0, 0);
    chk_rsp(0, 3, "R8 mask");
    send(3, 0, 0, 0, 0);
    chk_rsp(0, 0, "R8 cleared");
    send(2, 1, 12'h30, 0, 1);
    chk_rsp(0, 0, "R8 relaunch");
    tick();
    chk_iss(1, 1, 2, 12'h30, 0, "R8 relaunch beat");
    send(3, 0, 0, 0, 0, 4'b0010);
    chk_rsp(0, 0, "R8 same-cycle not yet");
    send(3, 0, 0, 0, 0);
    chk_rsp(0, 2, "R8 same-cycle next poll");
  endtask

  task automatic t_full(); // R9 R4
    send(2, 2, 12'h100, 0, 10);
    for (int i = 0; i < 4; i++) send(1, 2, 12'h200 + i, i, 0);
    @(negedge clk);
    cmd_valid = 1; cmd_op = 2'd1; cmd_bank = 2; #1;
    chk(cmd_ready == 1'b0, "R9 full blocks", cmd_ready, 0);
    cmd_bank = 3; #0.5;
    chk(cmd_ready == 1'b1, "R9 other bank ready", cmd_ready, 1);
    cmd_valid = 0;
    for (int i = 0; i < 6; i++) tick();
    chk_iss(2, 1, 2, 12'h109, 0, "R3 last beat");
    for (int i = 0; i < 4; i++) begin
      tick();
      chk_iss(2, 1, 1, 12'h200 + i, i, "R4 drain order");
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 0;
    t_reset();
    t_direct();
    t_lock();
    t_compute();
    t_done();
    t_full();
    tick();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule